// File: doc/BRIEF.md
# Diagnostic Port Code Display Sequencer

This block watches a simple I/O write bus for byte writes to the diagnostic port address (0080h) and shows the most recent byte as two hexadecimal seven-segment digits. Software writes a progress code to that port at the start of each step. If the system stops, the display keeps the last code that was written.

A small set of memory failure codes (2Ch, 2Eh, 30h) may be followed by a 16-bit failure bitmap on a separate load port. Bit n of the bitmap set means line or bit n failed, so 0002h marks line 1. Once such a bitmap is accepted, the display leaves its hold behaviour and steps through three items. It shows the checkpoint code, then the bitmap high byte, then the bitmap low byte. Each item stays up for `DWELL` clock cycles, and the three-step loop repeats until a new code is written.

The controller has four states. `ST_HOLD` shows the latched code. `ST_CODE`, `ST_HIGH` and `ST_LOW` are the three steps of the cycling loop. The transitions are:
- *accept*: a bitmap load while the latched code is a memory failure code, from any state, to `ST_CODE`.
- *advance*: a dwell timeout, `ST_CODE` to `ST_HIGH`, `ST_HIGH` to `ST_LOW` and `ST_LOW` to `ST_CODE`.
- *rewrite*: a port write, from any state, to `ST_HOLD`.

Top module: `diag_code_display`

## Requirements
- R1: After reset the displayed byte is 00h (both digits show glyph 0, pattern 3Fh) and the block is in hold mode.
- R2: A write (io_wr high) with io_addr equal to 0080h puts io_data on the display from the next clock cycle.
- R3: A write to any other address changes nothing on the display.
- R4: With no write to 0080h and no accepted bitmap, the display keeps the last value indefinitely.
- R5: A bitmap load while the latched code is 2Ch, 2Eh or 30h starts cycling. From the next cycle the display shows the code for DWELL cycles, then bitmap[15:8] for DWELL cycles, then bitmap[7:0] for DWELL cycles.
- R6: The three-item cycle repeats continuously, with the code following the low byte.
- R7: A bitmap load while the latched code is any other value is ignored.
- R8: A write to 0080h while cycling leaves cycling at once, and the new value is shown from the next cycle. A write to 0080h in the same cycle as a bitmap load wins, and that bitmap is ignored.
- R9: A bitmap load while cycling restarts the sequence at the code item, using the new bitmap.
- R10: Each digit is active high with seg[0]=a through seg[6]=g. The glyphs for 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. seg_hi shows the upper nibble and seg_lo the lower nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O write address |
| io_data | input | 8 | I/O write data |
| bmp_load | input | 1 | Failure bitmap load strobe |
| bmp_data | input | 16 | Failure bitmap |
| seg_hi | output | 7 | Segments of the upper-nibble digit |
| seg_lo | output | 7 | Segments of the lower-nibble digit |

## Verification
The bench checks dwell boundaries cycle by cycle against a model that counts edges from the accepting load. A timer that is off by one would drift the item changes early or late, and a missing wrap would stick on the low byte. It aims at a port write landing mid-item and a port write coinciding with a bitmap load. It also drives bitmap loads after non-failure codes, reloads while cycling, and writes to neighbouring addresses. A design that got these wrong would keep cycling, accept a stale bitmap, resume from the middle of a sequence, or latch stray bytes.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_CODE,
        ST_HIGH,
        ST_LOW
    } disp_state_t;

    function automatic logic is_bitmap_code(input logic [7:0] c);
        return (c == 8'h2C) || (c == 8'h2E) || (c == 8'h30);
    endfunction

endpackage

// File: rtl/seg7_decode.sv
module seg7_decode (
    input  logic [3:0] nib,
    output logic [6:0] seg
);
    always_comb begin
        unique case (nib)
            4'h0: seg = 7'h3F;
            4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;
            4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;
            4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;
            4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;
            4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;
            4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;
            4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;
            4'hF: seg = 7'h71;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int DWELL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/diag_seq_fsm.sv
module diag_seq_fsm
    import diag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bmp_load,
    input  logic [BMP_W-1:0]  bmp_data,
    input  logic              tick,
    output logic              restart,
    output disp_state_t       state,
    output logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] disp_byte
);
    disp_state_t       state_q, state_nx;
    logic [DATA_W-1:0] code_q;
    logic [BMP_W-1:0]  bmp_q;
    logic              accept;

    assign accept  = bmp_load && !wr_port && is_bitmap_code(code_q);
    assign restart = wr_port || accept;
    assign state   = state_q;
    assign code    = code_q;

    always_comb begin
        state_nx = state_q;
        if (wr_port) begin
            state_nx = ST_HOLD;
        end else if (accept) begin
            state_nx = ST_CODE;
        end else if (tick) begin
            unique case (state_q)
                ST_HOLD: state_nx = ST_HOLD;
                ST_CODE: state_nx = ST_HIGH;
                ST_HIGH: state_nx = ST_LOW;
                ST_LOW:  state_nx = ST_CODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            bmp_q  <= '0;
        end else begin
            if (wr_port) code_q <= wr_data;
            if (accept)  bmp_q  <= bmp_data;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD: disp_byte = code_q;
            ST_CODE: disp_byte = code_q;
            ST_HIGH: disp_byte = bmp_q[BMP_W-1 -: DATA_W];
            ST_LOW:  disp_byte = bmp_q[DATA_W-1:0];
        endcase
    end
endmodule

// File: rtl/diag_code_display.sv
module diag_code_display
    import diag_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          BMP_W     = 16,
    parameter logic [15:0] PORT_ADDR = 16'h0080,
    parameter int          DWELL     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    input  logic              bmp_load,
    input  logic [BMP_W-1:0]  bmp_data,
    output logic [6:0]        seg_hi,
    output logic [6:0]        seg_lo
);
    localparam int DIGITS = DATA_W / 4;

    logic              wr_port;
    logic              tick;
    logic              restart;
    disp_state_t       state;
    logic [DATA_W-1:0] code;
    logic [DATA_W-1:0] disp_byte;
    logic [6:0]        seg_vec [DIGITS];

    assign wr_port = io_wr && (io_addr == ADDR_W'(PORT_ADDR));

    diag_seq_fsm #(.DATA_W(DATA_W), .BMP_W(BMP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_port   (wr_port),
        .wr_data   (io_data),
        .bmp_load  (bmp_load),
        .bmp_data  (bmp_data),
        .tick      (tick),
        .restart   (restart),
        .state     (state),
        .code      (code),
        .disp_byte (disp_byte)
    );

    dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (state != ST_HOLD),
        .tick  (tick)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        seg7_decode u_dec (
            .nib (disp_byte[4*d +: 4]),
            .seg (seg_vec[d])
        );
    end

    assign seg_hi = seg_vec[DIGITS-1];
    assign seg_lo = seg_vec[0];
endmodule

// File: rtl/diag_code_display_chk.sv
module diag_code_display_chk
    import diag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_port,
    input logic [DATA_W-1:0] io_data,
    input logic              bmp_load,
    input disp_state_t       state,
    input logic [DATA_W-1:0] code,
    input logic [DATA_W-1:0] disp_byte
);
    // R2
    port_write_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> disp_byte == $past(io_data));

    // R8
    write_leaves_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> state == ST_HOLD);

    // R7
    plain_code_ignores_bitmap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmp_load && !wr_port && state == ST_HOLD && !is_bitmap_code(code)) |=> state == ST_HOLD);

    // R4
    hold_is_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !wr_port) |=> $stable(disp_byte));

    // R5
    high_follows_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && !wr_port && !(bmp_load && is_bitmap_code(code)))
        |=> (state == ST_HIGH || state == ST_LOW));
endmodule

bind diag_code_display diag_code_display_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_port   (wr_port),
    .io_data   (io_data),
    .bmp_load  (bmp_load),
    .state     (state),
    .code      (code),
    .disp_byte (disp_byte)
);

// File: tb/diag_code_display_tb.sv
`timescale 1ns/1ps
module diag_code_display_tb;
    localparam int D = 5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_wr = 0;
    logic [15:0] io_addr = 0;
    logic [7:0]  io_data = 0;
    logic        bmp_load = 0;
    logic [15:0] bmp_data = 0;
    logic [6:0]  seg_hi, seg_lo;

    int n_chk = 0, n_fail = 0;

    logic [7:0]  m_code = 0;
    logic [15:0] m_bmp = 0;
    bit          m_cyc = 0;
    int          m_t = 0;

    always #4 clk = ~clk;

    diag_code_display #(.DWELL(D)) u_dut (.*);

    function automatic logic [6:0] glyph(input logic [3:0] n);
        logic [6:0] tbl [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                                 7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
        return tbl[n];
    endfunction

    function automatic bit mem_err(input logic [7:0] c);
        return c == 8'h2C || c == 8'h2E || c == 8'h30;
    endfunction

    function automatic logic [7:0] exp_byte();
        if (!m_cyc) return m_code;
        case ((m_t / D) % 3)
            0: return m_code;
            1: return m_bmp[15:8];
            default: return m_bmp[7:0];
        endcase
    endfunction

    task automatic check(input string tag);
        logic [7:0] e;
        e = exp_byte();
        n_chk++;
        if (seg_hi !== glyph(e[7:4]) || seg_lo !== glyph(e[3:0])) begin
            n_fail++;
            $display("FAIL %s: seg_hi=%h seg_lo=%h expected %h %h (byte %h)",
                     tag, seg_hi, seg_lo, glyph(e[7:4]), glyph(e[3:0]), e);
        end
    endtask

    // drive at negedge, clock once, update model, check at next negedge
    task automatic step(input bit wr, input logic [15:0] a, input logic [7:0] dt,
                        input bit bl, input logic [15:0] bd);
        string tag;
        bit    w80;
        io_wr = wr; io_addr = a; io_data = dt; bmp_load = bl; bmp_data = bd;
        w80 = wr && a == 16'h0080;
        @(posedge clk);
        if (w80) begin
            tag = m_cyc ? "R8" : "R2";
            m_code = dt; m_cyc = 0; m_t = 0;
        end else if (bl && mem_err(m_code)) begin
            tag = m_cyc ? "R9" : "R5";
            m_bmp = bd; m_cyc = 1; m_t = 0;
        end else if (bl) begin
            tag = "R7";
            if (m_cyc) m_t = (m_t + 1) % (3 * D);
        end else if (wr) begin
            tag = "R3";
            if (m_cyc) m_t = (m_t + 1) % (3 * D);
        end else if (m_cyc) begin
            tag = "R6";
            m_t = (m_t + 1) % (3 * D);
        end else begin
            tag = "R4";
        end
        @(negedge clk);
        io_wr = 0; bl = 0; bmp_load = 0;
        check(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 8'h0, 0, 16'h0);
    endtask

    initial begin
        fork
            begin
                #1500000;
                n_chk++; n_fail++;
                $display("FAIL watchdog: run hung, expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1");
        idle(3);

        // R10: every glyph on both digits
        for (int v = 0; v < 16; v++) begin
            step(1, 16'h0080, 8'(v * 17), 0, 16'h0);
            check("R10");
        end
        // R3: neighbouring addresses
        step(1, 16'h0081, 8'hAA, 0, 16'h0);
        step(1, 16'h0180, 8'hBB, 0, 16'h0);
        step(1, 16'h007F, 8'hCC, 0, 16'h0);
        // R7: bitmap after non-error code
        step(1, 16'h0080, 8'h2D, 0, 16'h0);
        step(0, 16'h0, 8'h0, 1, 16'h1234);
        idle(4);
        // R5/R6: cycle several full loops
        step(1, 16'h0080, 8'h2C, 0, 16'h0);
        step(0, 16'h0, 8'h0, 1, 16'h0002);
        idle(6 * D + 2);
        // R9: reload mid-cycle
        idle(D + 1);
        step(0, 16'h0, 8'h0, 1, 16'h1020);
        idle(4 * D);
        // R8: write mid-item, and write coinciding with a bitmap load
        step(1, 16'h0080, 8'h30, 0, 16'h0);
        idle(2);
        step(1, 16'h0080, 8'h2E, 1, 16'hBEEF);
        idle(D + 2);
        step(0, 16'h0, 8'h0, 1, 16'hA5C3);
        idle(2 * D);
        step(1, 16'h0080, 8'h55, 0, 16'h0);
        idle(3);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] dv;
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 3))
                0: dv = 8'h2C;
                1: dv = 8'h2E;
                2: dv = 8'h30;
                default: dv = 8'($urandom);
            endcase
            if (r < 6)       step(1, 16'h0080, dv, $urandom_range(0, 3) == 0, 16'($urandom));
            else if (r < 12) step(1, 16'($urandom) | 16'h0100, 8'($urandom), 0, 16'h0);
            else if (r < 18) step(0, 16'h0, 8'h0, 1, 16'($urandom));
            else             step(0, 16'h0, 8'h0, 0, 16'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule